// File: doc/BRIEF.md
# Data Address Generator

This unit forms the data memory address for a microcoded processor. It keeps eight 16-bit address registers and a private adder, so the address for each microinstruction is formed in the same cycle as the control field arrives, alongside whatever the data arithmetic unit is doing. Three addressing modes are offered. In the register-direct mode, the selected register is the address. In the offset mode, a signed displacement from the microword is added to the selected register. In the indexed mode, a second register from the file is added to the selected one.

After the address has been formed, the selected register can be written back, advanced or retreated by a step of any size taken from the microword. Memory always sees the value from before that update, and the register changes on the same clock edge. A separate load path writes any register from the data bus. This lets software set pointers, and a load wins over an auto-update aimed at the same register.

Top module: `dag_unit`

## Requirements
- R1: Synchronous active-high `rst` sets all eight address registers to 0x0000.
- R2: With `op_en` high and `mode` = 0 (register-direct), `mem_addr` equals register[`base_sel`] in the same cycle, and `mem_addr_vld` is 1.
- R3: With `mode` = 1 (offset), `mem_addr` = register[`base_sel`] + `offset`, where `offset` is read as two's complement and the sum wraps modulo 2^16.
- R4: With `mode` = 2 (indexed), `mem_addr` = register[`base_sel`] + register[`index_sel`], wrapping modulo 2^16. The two selects may name the same register.
- R5: `mode` = 3 behaves exactly like register-direct.
- R6: With `op_en` high, `upd` = 1 writes register[`base_sel`] + `step` back to that register on the clock edge, and `upd` = 2 writes register[`base_sel`] − `step`. Both wrap modulo 2^16. `upd` = 0 or 3 leaves the register unchanged. In every case the address shown in that cycle is the value before the update.
- R7: `load_en` high writes `load_data` into register[`load_sel`] on the clock edge, whatever the value of `op_en`. The new value is seen from the next cycle on. A read of the same register in the load cycle returns the old value.
- R8: When a load and an auto-update target the same register in one cycle, the loaded value is kept. When they target different registers, both take effect.
- R9: With `op_en` low, `mem_addr` is 0x0000, `mem_addr_vld` is 0, and no auto-update takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_en | input | 1 | Microword requests a memory address this cycle |
| mode | input | 2 | Addressing mode: 0 direct, 1 offset, 2 indexed, 3 as direct |
| base_sel | input | 3 | Register that gives the base and receives the auto-update |
| index_sel | input | 3 | Register added in indexed mode |
| offset | input | 16 | Signed displacement for offset mode |
| step | input | 16 | Auto-update step size |
| upd | input | 2 | Write-back: 0 none, 1 add step, 2 subtract step, 3 none |
| load_en | input | 1 | Write `load_data` into a register |
| load_sel | input | 3 | Register written by the load path |
| load_data | input | 16 | Value from the data bus |
| mem_addr | output | 16 | Address presented to data memory |
| mem_addr_vld | output | 1 | Address is valid |

## Verification
The hardest case to reach is a cycle where a bus load and an auto-update land on the same register, and the result is only visible one cycle later through a read of that register. Directed steps create this clash on purpose. They also create the neighbouring case, where the two writes go to different registers, and then read both registers back in direct mode. A long random phase then picks `load_sel` from the full range and tends to hit the base register, so clashes, decrements that wrap below zero, and same-register indexing occur many times. A behavioural model checks every cycle.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int ADDR_W = 16;
    localparam int NUM_REGS = 8;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_OFFSET = 2'd1,
        AM_INDEX  = 2'd2,
        AM_ALIAS  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        UP_NONE  = 2'd0,
        UP_INC   = 2'd1,
        UP_DEC   = 2'd2,
        UP_SPARE = 2'd3
    } upd_e;

    function automatic logic [ADDR_W-1:0] wrap_sum(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] b,
        input logic              subtract
    );
        return subtract ? (a - b) : (a + b);
    endfunction

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rd_a_sel,
    input  logic [SW-1:0] rd_b_sel,
    output logic [AW-1:0] rd_a,
    output logic [AW-1:0] rd_b,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [AW-1:0] upd_val,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [AW-1:0] ld_val
);

    logic [AW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_ld;
        logic hit_upd;
        assign hit_ld  = ld_en  && (ld_sel  == SW'(g));
        assign hit_upd = upd_en && (upd_sel == SW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (hit_ld) begin
                regs[g] <= ld_val;
            end else if (hit_upd) begin
                regs[g] <= upd_val;
            end
        end
    end

    assign rd_a = regs[rd_a_sel];
    assign rd_b = regs[rd_b_sel];

endmodule

// File: rtl/dag_addr_adder.sv
module dag_addr_adder
    import dag_pkg::*;
#(
    parameter int AW = 16
) (
    input  amode_e        mode,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] operand;

    always_comb begin
        case (mode)
            AM_OFFSET: operand = disp;
            AM_INDEX:  operand = index_val;
            default:   operand = '0;
        endcase
        addr = base_val + operand;
    end

endmodule

// File: rtl/dag_step_unit.sv
module dag_step_unit
    import dag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          active,
    input  upd_e          upd,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    output logic          wr_en,
    output logic [AW-1:0] wr_val
);

    always_comb begin
        wr_en  = active && ((upd == UP_INC) || (upd == UP_DEC));
        wr_val = (upd == UP_DEC) ? (cur - step) : (cur + step);
    end

endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NREG = NUM_REGS,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_en,
    input  logic [1:0]    mode,
    input  logic [SW-1:0] base_sel,
    input  logic [SW-1:0] index_sel,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] step,
    input  logic [1:0]    upd,
    input  logic          load_en,
    input  logic [SW-1:0] load_sel,
    input  logic [AW-1:0] load_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_addr_vld
);

    logic [AW-1:0] base_val;
    logic [AW-1:0] index_val;
    logic [AW-1:0] raw_addr;
    logic          upd_wr;
    logic [AW-1:0] upd_val;

    dag_regfile #(.AW(AW), .NREG(NREG)) i_file (
        .clk      (clk),
        .rst      (rst),
        .rd_a_sel (base_sel),
        .rd_b_sel (index_sel),
        .rd_a     (base_val),
        .rd_b     (index_val),
        .upd_en   (upd_wr),
        .upd_sel  (base_sel),
        .upd_val  (upd_val),
        .ld_en    (load_en),
        .ld_sel   (load_sel),
        .ld_val   (load_data)
    );

    dag_addr_adder #(.AW(AW)) i_adder (
        .mode      (amode_e'(mode)),
        .base_val  (base_val),
        .index_val (index_val),
        .disp      (offset),
        .addr      (raw_addr)
    );

    dag_step_unit #(.AW(AW)) i_step (
        .active (op_en),
        .upd    (upd_e'(upd)),
        .cur    (base_val),
        .step   (step),
        .wr_en  (upd_wr),
        .wr_val (upd_val)
    );

    assign mem_addr     = op_en ? raw_addr : '0;
    assign mem_addr_vld = op_en;

endmodule

// File: rtl/dag_unit_chk.sv
module dag_unit_chk #(
    parameter int AW = 16,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          op_en,
    input logic [1:0]    mode,
    input logic [SW-1:0] base_sel,
    input logic [AW-1:0] step,
    input logic [1:0]    upd,
    input logic          load_en,
    input logic [SW-1:0] load_sel,
    input logic [AW-1:0] load_data,
    input logic [AW-1:0] mem_addr
);

    // R1: first direct read after reset shows zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && op_en && mode == 2'd0) |-> mem_addr == '0);

    // R6: post-increment visible on the next direct read of the same register
    a_r6_post_inc: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_en && mode == 2'd0 && upd == 2'd1
            && !(load_en && load_sel == base_sel))
         && op_en && mode == 2'd0 && base_sel == $past(base_sel))
        |-> mem_addr == AW'($past(mem_addr) + $past(step)));

    // R6: post-decrement visible on the next direct read of the same register
    a_r6_post_dec: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_en && mode == 2'd0 && upd == 2'd2
            && !(load_en && load_sel == base_sel))
         && op_en && mode == 2'd0 && base_sel == $past(base_sel))
        |-> mem_addr == AW'($past(mem_addr) - $past(step)));

    // R7, R8: a load is always what the next read of that register returns
    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(load_en) && op_en && mode == 2'd0
         && base_sel == $past(load_sel))
        |-> mem_addr == $past(load_data));

endmodule

bind dag_unit dag_unit_chk #(.AW(AW), .SW(SW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .op_en     (op_en),
    .mode      (mode),
    .base_sel  (base_sel),
    .step      (step),
    .upd       (upd),
    .load_en   (load_en),
    .load_sel  (load_sel),
    .load_data (load_data),
    .mem_addr  (mem_addr)
);

// File: tb/test_dag_unit.sv
`timescale 1ns/1ps
module test_dag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_en = 1'b0;
    logic [1:0]  mode = '0;
    logic [2:0]  base_sel = '0;
    logic [2:0]  index_sel = '0;
    logic [15:0] offset = '0;
    logic [15:0] step = '0;
    logic [1:0]  upd = '0;
    logic        load_en = 1'b0;
    logic [2:0]  load_sel = '0;
    logic [15:0] load_data = '0;
    logic [15:0] mem_addr;
    logic        mem_addr_vld;

    int total = 0;
    int bad = 0;
    logic [15:0] model [8];

    always #2.5 clk = ~clk;

    dag_unit i_dag_unit (
        .clk(clk), .rst(rst), .op_en(op_en), .mode(mode),
        .base_sel(base_sel), .index_sel(index_sel), .offset(offset),
        .step(step), .upd(upd), .load_en(load_en), .load_sel(load_sel),
        .load_data(load_data), .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld)
    );

    function automatic logic [15:0] expect_addr();
        logic [15:0] b;
        if (!op_en) return 16'h0000;
        b = model[base_sel];
        case (mode)
            2'd1:    return 16'(b + offset);
            2'd2:    return 16'(b + model[index_sel]);
            default: return b;
        endcase
    endfunction

    task automatic run(input string tag);
        logic [15:0] exp_a;
        logic [15:0] nxt [8];
        #1;
        exp_a = expect_addr();
        total++;
        if (mem_addr !== exp_a || mem_addr_vld !== op_en) begin
            bad++;
            $display("FAIL %s: mem_addr=%h vld=%b expected %h vld=%b",
                     tag, mem_addr, mem_addr_vld, exp_a, op_en);
        end
        for (int i = 0; i < 8; i++) nxt[i] = model[i];
        if (op_en && upd == 2'd1) nxt[base_sel] = 16'(model[base_sel] + step);
        if (op_en && upd == 2'd2) nxt[base_sel] = 16'(model[base_sel] - step);
        if (load_en) nxt[load_sel] = load_data;
        @(posedge clk);
        for (int i = 0; i < 8; i++) model[i] = rst ? 16'h0000 : nxt[i];
        @(negedge clk);
    endtask

    task automatic idle();
        op_en = 0; load_en = 0; upd = 0; mode = 0; offset = 0; step = 0;
    endtask

    task automatic rd(input logic [2:0] r, input string tag);
        idle(); op_en = 1; base_sel = r; run(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'h0000;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1: reset state
        for (int i = 0; i < 8; i++) rd(3'(i), "R1");
        // R7, R9: loads while op_en low
        for (int i = 0; i < 8; i++) begin
            idle(); load_en = 1; load_sel = 3'(i);
            load_data = (i == 7) ? 16'hFFF0 : 16'(i * 16'h1111 + 5);
            run("R9");
        end
        // R7: same-cycle read of loading register returns old value
        idle(); op_en = 1; base_sel = 1; load_en = 1; load_sel = 1; load_data = 16'h0BAD; run("R7");
        rd(1, "R7");
        // R2: direct
        for (int i = 0; i < 8; i++) rd(3'(i), "R2");
        // R3: offset, positive, negative, wrap
        idle(); op_en = 1; mode = 1; base_sel = 2; offset = 16'h0010; run("R3");
        idle(); op_en = 1; mode = 1; base_sel = 2; offset = 16'hFFF0; run("R3");
        idle(); op_en = 1; mode = 1; base_sel = 7; offset = 16'h0020; run("R3");
        // R4: indexed, incl. same register and wrap
        idle(); op_en = 1; mode = 2; base_sel = 7; index_sel = 1; run("R4");
        idle(); op_en = 1; mode = 2; base_sel = 7; index_sel = 7; run("R4");
        // R5: alias mode
        idle(); op_en = 1; mode = 3; base_sel = 4; offset = 16'h5555; index_sel = 6; run("R5");
        // R6: increment by large step
        idle(); op_en = 1; base_sel = 2; upd = 1; step = 16'h1234; run("R6");
        rd(2, "R6");
        // R6: decrement wrapping below zero
        idle(); op_en = 1; mode = 1; offset = 16'h0003; base_sel = 0; upd = 2; step = 16'h0008; run("R6");
        rd(0, "R6");
        // R6: spare code leaves register alone
        idle(); op_en = 1; base_sel = 3; upd = 3; step = 16'h0100; run("R6");
        rd(3, "R6");
        // R8: clash, load wins
        idle(); op_en = 1; base_sel = 3; upd = 1; step = 16'h0001;
        load_en = 1; load_sel = 3; load_data = 16'hABCD; run("R8");
        rd(3, "R8");
        // R8: different registers, both take effect
        idle(); op_en = 1; base_sel = 4; upd = 1; step = 16'h0040;
        load_en = 1; load_sel = 5; load_data = 16'h2468; run("R8");
        rd(4, "R8");
        rd(5, "R8");
        // R9: op_en low suppresses update
        idle(); base_sel = 4; upd = 1; step = 16'h0777; mode = 1; run("R9");
        rd(4, "R9");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            string tag;
            op_en     = ($urandom_range(0, 7) != 0);
            mode      = 2'($urandom);
            base_sel  = 3'($urandom);
            index_sel = ($urandom_range(0, 3) == 0) ? base_sel : 3'($urandom);
            offset    = 16'($urandom);
            step      = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 4)) : 16'($urandom);
            upd       = 2'($urandom);
            load_en   = ($urandom_range(0, 2) == 0);
            load_sel  = ($urandom_range(0, 1) == 0) ? base_sel : 3'($urandom);
            load_data = 16'($urandom);
            if (!op_en) tag = "R9";
            else if (load_en && load_sel == base_sel && upd inside {2'd1, 2'd2}) tag = "R8";
            else if (upd inside {2'd1, 2'd2}) tag = "R6";
            else if (mode == 2'd1) tag = "R3";
            else if (mode == 2'd2) tag = "R4";
            else if (mode == 2'd3) tag = "R5";
            else tag = "R2";
            run(tag);
        end
        // R1: reset in mid-run clears everything
        idle(); rst = 1; run("R1");
        rst = 0;
        for (int i = 0; i < 8; i++) rd(3'(i), "R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule